// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Unit

This unit is the multiplier of a processor core's execute stage. A one-cycle start request hands it two 32-bit operands, an accumulator pair and an operation code. It then runs the product over several cycles and returns a low and a high result word with a one-cycle done pulse. There are six operations:

- a truncated 32-bit product;
- a truncated 32-bit multiply-accumulate;
- a 64-bit product, signed or unsigned;
- a 64-bit multiply-accumulate, signed or unsigned, which adds the product to an existing high:low value.

The multiplier operand `mul_b` is consumed one 8-bit slice per cycle, least significant slice first. The run stops as soon as the slices still pending carry no information: they are all zeros, or, in the signed 64-bit forms, all ones. When the pending slices are all ones, the unit subtracts the shifted multiplicand once to make up for them. A small multiplier therefore returns in two cycles, counting the request cycle. A full-width multiplier returns in five.

Top module: `seq_mac_unit`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `res_lo` and `res_hi` are 0.
- R2: Code 0 (32-bit product): `res_lo` is bits 31..0 of `mul_a*mul_b`, and `res_hi` is 0.
- R3: Code 1 (32-bit multiply-accumulate): `res_lo` is `(mul_a*mul_b + acc_lo) mod 2^32`, and `res_hi` is 0.
- R4: Code 2 (unsigned long product): `{res_hi,res_lo}` is the unsigned 64-bit product of `mul_a` and `mul_b`.
- R5: Code 3 (unsigned long accumulate): `{res_hi,res_lo}` is `(unsigned product + {acc_hi,acc_lo}) mod 2^64`.
- R6: Code 4 (signed long product): `{res_hi,res_lo}` is the two's-complement 64-bit product of the operands, both taken as signed.
- R7: Code 5 (signed long accumulate): `{res_hi,res_lo}` is `(signed product + {acc_hi,acc_lo}) mod 2^64`.
- R8: Code 6 behaves as code 0 and code 7 as code 1. Bit 0 of `op_sel` selects accumulate; bits 2..1 select the form: 01 is unsigned long, 10 is signed long, and 00 or 11 is 32-bit.
- R9: Let k be the smallest value in 1..4 for which `mul_b` shifted right by 8k bits is all zeros. For the signed long codes the shift is arithmetic, and all ones also qualifies. `done` is high in the cycle that follows the k-th rising edge after the edge that samples `start`.
- R10: `busy` is high from the cycle after a start is accepted through the done cycle, and low otherwise. `done` is high for exactly one cycle.
- R11: A `start` raised while `busy` is high, including during the done cycle, is ignored. The running result and its timing are unchanged, and no extra operation follows.
- R12: `res_lo` and `res_hi` change only on the edge that raises `done`, and they hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request, sampled while idle |
| op_sel | input | 3 | Operation code (see R2 to R8) |
| mul_a | input | 32 | Multiplicand |
| mul_b | input | 32 | Multiplier, scanned 8 bits per cycle |
| acc_lo | input | 32 | Accumulator low word; also the 32-bit accumulator |
| acc_hi | input | 32 | Accumulator high word for the long accumulate forms |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word, 0 for the 32-bit forms |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
All eight codes are swept over a grid of corner operands with zero and non-zero accumulators. The grid includes 0, ±1, 0x80000000, 0x7FFFFFFF and values that straddle every 8-bit slice boundary, both positive and sign-extended negative. These grid values separate the signed from the unsigned forms and exercise every early-stop length k = 1..4, including the corrective subtraction when the pending slices are all ones.

A pseudo-random sweep then exercises carries between slices that the grid values do not produce. Further runs raise `start` again one cycle into an operation and again in its done cycle. These runs tell a correctly ignored request apart from one that corrupts the result or launches a second operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DEF_DATA_W  = 32;
    localparam int DEF_SLICE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;

    typedef struct packed {
        logic accum;
        logic wide;
        logic sgn;
    } mac_mode_t;

    function automatic mac_mode_t decode_op(input logic [2:0] code);
        mac_mode_t m;
        m.accum = code[0];
        m.wide  = (code[2:1] == 2'b01) || (code[2:1] == 2'b10);
        m.sgn   = (code[2:1] == 2'b10);
        return m;
    endfunction

endpackage

// File: rtl/mac_load_prep.sv
module mac_load_prep
    import mac_pkg::*;
#(
    parameter int DW = DEF_DATA_W,
    localparam int PW = 2 * DW
) (
    input  mac_mode_t       mode_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   acc_lo_i,
    input  logic [DW-1:0]   acc_hi_i,
    output logic [PW-1:0]   sum_init_o,
    output logic [PW-1:0]   mcand_init_o
);

    logic [PW-1:0] acc_sel;

    always_comb begin
        if (!mode_i.accum)
            acc_sel = '0;
        else if (mode_i.wide)
            acc_sel = {acc_hi_i, acc_lo_i};
        else
            acc_sel = {{DW{1'b0}}, acc_lo_i};
    end

    always_comb begin
        if (mode_i.sgn)
            mcand_init_o = {{DW{a_i[DW-1]}}, a_i};
        else
            mcand_init_o = {{DW{1'b0}}, a_i};
    end

    assign sum_init_o = acc_sel;

endmodule

// File: rtl/mac_step.sv
module mac_step
    import mac_pkg::*;
#(
    parameter int DW = DEF_DATA_W,
    parameter int CW = DEF_SLICE_W,
    localparam int PW = 2 * DW
) (
    input  logic [PW-1:0] sum_i,
    input  logic [PW-1:0] mcand_i,
    input  logic [DW-1:0] mplier_i,
    input  logic          sgn_i,
    output logic [PW-1:0] sum_o,
    output logic [PW-1:0] mcand_o,
    output logic [DW-1:0] mplier_o,
    output logic          last_o
);

    logic [PW-1:0] slice_ext;
    logic [PW-1:0] partial;
    logic [PW-1:0] sum_add;
    logic [DW-1:0] rest;
    logic          rest_zero;
    logic          rest_ones;

    assign slice_ext = {{(PW-CW){1'b0}}, mplier_i[CW-1:0]};
    assign partial   = mcand_i * slice_ext;
    assign sum_add   = sum_i + partial;

    always_comb begin
        if (sgn_i)
            rest = DW'($signed(mplier_i) >>> CW);
        else
            rest = mplier_i >> CW;
    end

    assign rest_zero = (rest == '0);
    assign rest_ones = sgn_i && (&rest);
    assign mcand_o   = mcand_i << CW;
    assign mplier_o  = rest;
    assign last_o    = rest_zero || rest_ones;

    // pending slices worth -1 at this weight: remove one shifted multiplicand
    assign sum_o = rest_ones ? (sum_add - mcand_o) : sum_add;

endmodule

// File: rtl/seq_mac_unit.sv
module seq_mac_unit
    import mac_pkg::*;
#(
    parameter int DW = DEF_DATA_W,
    parameter int CW = DEF_SLICE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    op_sel,
    input  logic [DW-1:0] mul_a,
    input  logic [DW-1:0] mul_b,
    input  logic [DW-1:0] acc_lo,
    input  logic [DW-1:0] acc_hi,
    output logic [DW-1:0] res_lo,
    output logic [DW-1:0] res_hi,
    output logic          busy,
    output logic          done
);

    localparam int PW = 2 * DW;

    run_state_t    state_q;
    mac_mode_t     mode_q;
    mac_mode_t     mode_in;
    logic [PW-1:0] sum_q, mcand_q;
    logic [DW-1:0] mplier_q;
    logic [DW-1:0] lo_q, hi_q;
    logic [PW-1:0] sum_init, mcand_init;
    logic [PW-1:0] sum_nx, mcand_nx;
    logic [DW-1:0] mplier_nx;
    logic          last;
    logic          long_run;

    assign mode_in  = decode_op(op_sel);
    assign long_run = mode_q.wide;

    mac_load_prep #(.DW(DW)) u_prep (
        .mode_i       (mode_in),
        .a_i          (mul_a),
        .acc_lo_i     (acc_lo),
        .acc_hi_i     (acc_hi),
        .sum_init_o   (sum_init),
        .mcand_init_o (mcand_init)
    );

    mac_step #(.DW(DW), .CW(CW)) u_step (
        .sum_i    (sum_q),
        .mcand_i  (mcand_q),
        .mplier_i (mplier_q),
        .sgn_i    (mode_q.sgn),
        .sum_o    (sum_nx),
        .mcand_o  (mcand_nx),
        .mplier_o (mplier_nx),
        .last_o   (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= '0;
            sum_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q   <= mode_in;
                        sum_q    <= sum_init;
                        mcand_q  <= mcand_init;
                        mplier_q <= mul_b;
                        state_q  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    sum_q    <= sum_nx;
                    mcand_q  <= mcand_nx;
                    mplier_q <= mplier_nx;
                    if (last) begin
                        lo_q    <= sum_nx[DW-1:0];
                        hi_q    <= long_run ? sum_nx[PW-1:DW] : '0;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = (state_q == ST_DONE);
    assign res_lo = lo_q;
    assign res_hi = hi_q;

endmodule

// File: rtl/seq_mac_unit_chk.sv
module seq_mac_unit_chk #(
    parameter int DW = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] res_lo,
    input logic [DW-1:0] res_hi,
    input logic          is_long
);

    localparam int NSL = DW / CW;
    localparam int CNW = $clog2(NSL + 2) + 1;

    logic [CNW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            busy_cnt <= '0;
        else if (!busy)
            busy_cnt <= '0;
        else if (busy_cnt != '1)
            busy_cnt <= busy_cnt + 1'b1;
    end

    // R10: the completion pulse only appears inside an operation
    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: an accepted start raises busy, and done is not immediate
    p_start_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));

    // R11: a start seen during the done cycle does not relaunch
    p_no_relaunch_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R9: at most one cycle per multiplier slice before done
    p_latency_bound_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt <= CNW'(NSL)));

    // R12: result words move only with done
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_lo) && $stable(res_hi)));

    // R2: short forms leave the high word clear
    p_short_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !is_long) |-> (res_hi == '0));

endmodule

bind seq_mac_unit seq_mac_unit_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .res_lo  (res_lo),
    .res_hi  (res_hi),
    .is_long (long_run)
);

// File: tb/seq_mac_unit_test.sv
`timescale 1ns/1ps
module seq_mac_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] mul_a = '0, mul_b = '0, acc_lo = '0, acc_hi = '0;
    logic [31:0] res_lo, res_hi;
    logic        busy, done;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always #2.5 clk = ~clk;

    seq_mac_unit uut (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .mul_a(mul_a), .mul_b(mul_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .res_lo(res_lo), .res_hi(res_hi), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // expected result and slice count from the requirements
    task automatic model(input logic [2:0] op, input logic [31:0] a, b, al, ah,
                         output logic [31:0] elo, ehi, output int ek);
        logic        wide, sgn;
        logic [63:0] prod, acc, full, rest;
        wide = (op[2:1] == 2'b01) || (op[2:1] == 2'b10);
        sgn  = (op[2:1] == 2'b10);
        if (sgn)
            prod = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        else
            prod = {32'h0, a} * {32'h0, b};
        if (!op[0])    acc = 64'h0;
        else if (wide) acc = {ah, al};
        else           acc = {32'h0, al};
        full = prod + acc;
        elo  = full[31:0];
        ehi  = wide ? full[63:32] : 32'h0;
        ek   = 4;
        for (int kk = 4; kk >= 1; kk--) begin
            if (sgn) rest = $signed({{32{b[31]}}, b}) >>> (8 * kk);
            else     rest = {32'h0, b} >> (8 * kk);
            if (rest == 64'h0 || (sgn && rest == {64{1'b1}})) ek = kk;
        end
    endtask

    // poke: raise start again one cycle in and in the done cycle (R11)
    task automatic run_op(input logic [2:0] op, input logic [31:0] a, b, al, ah,
                          input bit poke);
        logic [31:0] elo, ehi, plo, phi;
        int ek, n;
        bit got;
        model(op, a, b, al, ah, elo, ehi, ek);
        plo = res_lo;
        phi = res_hi;
        op_sel = op; mul_a = a; mul_b = b; acc_lo = al; acc_hi = ah;
        start = 1'b1;
        @(posedge clk);
        n = 0;
        got = 0;
        while (!got && n < 12) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && n == 0) begin
                start = 1'b1;
                op_sel = op ^ 3'd1; mul_a = ~a; mul_b = 32'hFFFF_FFFF;
            end
            chk(busy == 1'b1, "R10 busy during run", {63'h0, busy}, 64'h1);
            if (done) got = 1;
            else begin
                chk(res_lo == plo && res_hi == phi, "R12 hold while running",
                    {res_hi, res_lo}, {phi, plo});
                @(posedge clk);
                n++;
            end
        end
        chk(got && n == ek, "R9 latency", 64'(n), 64'(ek));
        chk(res_lo == elo, tag_of(op), {32'h0, res_lo}, {32'h0, elo});
        chk(res_hi == ehi, tag_of(op), {32'h0, res_hi}, {32'h0, ehi});
        if (poke) start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (poke)
            chk(!busy && !done, "R11 start in done cycle ignored",
                {62'h0, busy, done}, 64'h0);
        else
            chk(!busy && !done, "R10 idle after done", {62'h0, busy, done}, 64'h0);
        chk(res_lo == elo && res_hi == ehi, "R12 hold after done",
            {res_hi, res_lo}, {ehi, elo});
    endtask

    logic [31:0] corners [14];

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
        report();
        $finish;
    end

    initial begin
        corners[0]  = 32'h0000_0000; corners[1]  = 32'h0000_0001;
        corners[2]  = 32'hFFFF_FFFF; corners[3]  = 32'h8000_0000;
        corners[4]  = 32'h7FFF_FFFF; corners[5]  = 32'h0000_00FF;
        corners[6]  = 32'h0000_0100; corners[7]  = 32'h0000_FFFF;
        corners[8]  = 32'h0001_0000; corners[9]  = 32'h00FF_FFFF;
        corners[10] = 32'h0100_0000; corners[11] = 32'hFFFF_FF00;
        corners[12] = 32'hFFFF_8000; corners[13] = 32'h1234_5678;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1 flags after reset", {62'h0, busy, done}, 64'h0);
        chk(res_lo == 0 && res_hi == 0, "R1 results after reset", {res_hi, res_lo}, 64'h0);

        // corner grid, codes 0..5 (R2..R7), with and without accumulator
        for (int op = 0; op < 6; op++)
            for (int i = 0; i < 14; i++)
                for (int j = 0; j < 14; j++)
                    run_op(3'(op), corners[i], corners[j],
                           corners[(i + j) % 14], corners[(i * 3 + j) % 14], 1'b0);

        // R6 named signed corners
        run_op(3'd4, 32'h8000_0000, 32'h8000_0000, 0, 0, 1'b0);
        chk(res_hi == 32'h4000_0000 && res_lo == 0, "R6 min*min",
            {res_hi, res_lo}, 64'h4000_0000_0000_0000);
        run_op(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1'b0);
        chk(res_hi == 0 && res_lo == 1, "R6 -1*-1", {res_hi, res_lo}, 64'h1);
        run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1'b0);
        chk({res_hi, res_lo} == 64'hFFFF_FFFE_0000_0001, "R4 max*max",
            {res_hi, res_lo}, 64'hFFFF_FFFE_0000_0001);

        // R8 reserved codes alias the short forms
        for (int i = 0; i < 14; i++) begin
            run_op(3'd6, corners[i], corners[13 - i], corners[i], corners[i], 1'b0);
            run_op(3'd7, corners[13 - i], corners[i], corners[(i + 5) % 14], 32'hDEAD_BEEF, 1'b0);
        end

        // pseudo-random sweep over all codes
        for (int t = 0; t < 400; t++) begin
            logic [31:0] ra, rb, rl, rh;
            ra = next_rand(); rb = next_rand(); rl = next_rand(); rh = next_rand();
            if (t % 4 == 1) rb = rb >> (8 * (t % 3 + 1));
            if (t % 4 == 2) rb = $signed(rb | 32'h8000_0000) >>> (8 * (t % 3 + 1));
            run_op(3'(t % 8), ra, rb, rl, rh, 1'b0);
        end

        // R11 restart requests while busy
        for (int t = 0; t < 48; t++) begin
            logic [31:0] ra, rb;
            ra = next_rand(); rb = next_rand();
            if (t % 2 == 0) rb = rb >> (8 * (t % 4));
            run_op(3'(t % 6), ra, rb, next_rand(), next_rand(), 1'b1);
        end

        report();
        $finish;
    end

endmodule